// File: doc/BRIEF.md
# Regulator Enable and Soft-Start Sequencer

This block sequences the start-up and shutdown of a step-down regulator's control loop. It watches an enable pin, an input-undervoltage lockout flag and an over-temperature flag. When enable is high and neither fault is present, it first waits a fixed time so the reference can settle. It then raises a digital reference code from zero to full scale in equal steps. The loop's digital-to-analog converter follows that code. Once the code is at full scale, the block reports that start-up is complete.

Dropping enable, a lockout or an over-temperature event turns the power switches off in the same cycle and sends the sequencer back to idle with the reference at zero. Any later start runs the whole wake-up delay and soft-start ramp again. The output discharge switch is closed only while enable is low. A thermal or lockout shutdown with enable still high does not discharge the output. The over-temperature flag is expected to come from a sensor that already has its own hysteresis: it sets near 140 °C and clears near 120 °C.

Top module: `supply_start_seq`

## Requirements
- R1: While reset is held, and after reset with enable low, `ref_code` is 0, `sw_en` is 0, `gate_off` is 1, `start_done` is 0 and `dis_en` is 1.
- R2: After enable is sampled high with no fault, the sequencer stays in a wake-up phase for exactly WAKE_CYCLES clock edges. During that phase `sw_en` is 0 and `ref_code` is 0. Switching starts on the edge after the phase ends.
- R3: While `en_in` is low, `gate_off` and `dis_en` are 1 and `sw_en` is 0, in the same cycle and without waiting for a clock edge. `dis_en` is 0 whenever `en_in` is high.
- R4: During the ramp, `ref_code` rises by exactly one every STEP_CYCLES edges. It starts at 0 and ends at the all-ones code 2^CODE_W-1, and it never moves by more than one step per edge.
- R5: `start_done` goes to 1 on the edge after `ref_code` reaches full scale. It is only ever 1 while `ref_code` is at full scale.
- R6: While `lockout_in` is 1, enable has no effect: no wake-up, `sw_en` stays 0 and `ref_code` stays 0.
- R7: `hot_in` high shuts the regulator down: `gate_off` goes to 1 at once, and `dis_en` stays 0 if enable is high. When `hot_in` clears, the restart runs a full wake-up delay and a fresh ramp from code 0.
- R8: A lockout or over-temperature event during the wake-up or the ramp aborts the start. `ref_code` is 0 on the next edge, and the next start runs the wake-up delay from its beginning.
- R9: `start_done` clears on the edge after any shutdown cause: enable low, lockout or over-temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Regulator enable, active high |
| lockout_in | input | 1 | Input supply below the lockout threshold |
| hot_in | input | 1 | Over-temperature flag with hysteresis from the sensor |
| ref_code | output | CODE_W | Soft-start reference code for the loop DAC |
| sw_en | output | 1 | Switching permitted |
| gate_off | output | 1 | Force both power switches off |
| dis_en | output | 1 | Close the output discharge switch |
| start_done | output | 1 | Ramp finished, reference at full scale |

## Verification
The bench builds the block with CODE_W=4, WAKE_CYCLES=8 and STEP_CYCLES=3. A complete start then takes only 54 edges, while the step prescaler still has a real multi-cycle period. Many starts, aborts and restarts therefore fit into one run. The short wake-up phase lets the bench hit its first and last edges exactly, and reach the boundaries between ramp steps and full scale. The small code width still exercises the all-ones end code and the handover to the finished state.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_RAMP = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/seq_wake_timer.sv
module seq_wake_timer #(
  parameter int WAKE_CYCLES = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(WAKE_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = LOAD_VAL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD_VAL;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_WAKE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1 || !$past(run))); // R2

endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int CODE_W      = 8,
  parameter int STEP_CYCLES = 216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [CODE_W-1:0] code
);
  localparam int PW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(STEP_CYCLES - 1);

  logic [PW-1:0]     pre_q, pre_d;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    pre_d  = pre_q;
    code_d = code_q;
    if (clr) begin
      pre_d  = '0;
      code_d = '0;
    end else if (adv) begin
      if (pre_q == P_LAST) begin
        pre_d  = '0;
        code_d = code_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      code_q <= '0;
    end else begin
      pre_q  <= pre_d;
      code_q <= code_d;
    end
  end

  assign code = code_q;

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv) |-> (code_q == $past(code_q) || code_q == CODE_W'($past(code_q) + 1'b1) || $past(clr))); // R4

endmodule

// File: rtl/supply_start_seq.sv
module supply_start_seq #(
  parameter int CODE_W      = 8,
  parameter int WAKE_CYCLES = 30000,
  parameter int STEP_CYCLES = 216
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_in,
  input  logic              lockout_in,
  input  logic              hot_in,
  output logic [CODE_W-1:0] ref_code,
  output logic              sw_en,
  output logic              gate_off,
  output logic              dis_en,
  output logic              start_done
);
  import seq_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  seq_state_e state_q, state_d;
  logic       go;
  logic       wake_over;
  logic       ramp_clr, ramp_adv;
  logic       active;

  assign go = en_in & ~lockout_in & ~hot_in;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_WAKE;
      ST_WAKE: begin
        if (!go)            state_d = ST_IDLE;
        else if (wake_over) state_d = ST_RAMP;
      end
      ST_RAMP: begin
        if (!go)                       state_d = ST_IDLE;
        else if (ref_code == CODE_MAX) state_d = ST_RUN;
      end
      ST_RUN:  if (!go) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  seq_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_WAKE),
    .expired (wake_over)
  );

  assign ramp_clr = !(state_d == ST_RAMP || state_d == ST_RUN);
  assign ramp_adv = (state_q == ST_RAMP) && (state_d == ST_RAMP);

  seq_ramp #(.CODE_W(CODE_W), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ramp_clr),
    .adv   (ramp_adv),
    .code  (ref_code)
  );

  assign active     = (state_q == ST_RAMP) || (state_q == ST_RUN);
  assign sw_en      = go & active;
  assign gate_off   = ~sw_en;
  assign dis_en     = ~en_in;
  assign start_done = (state_q == ST_RUN);

  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |-> (ref_code == CODE_MAX)); // R5

  AST_WAKE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |-> (ref_code == '0 && !sw_en)); // R2

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!go) |=> (ref_code == '0 && !start_done)); // R9

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_in && $past(lockout_in)) |-> (state_q == ST_IDLE && !sw_en)); // R6

  AST_DISCHARGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en |-> (gate_off && !sw_en)); // R3

endmodule

// File: tb/supply_start_seq_tb.sv
`timescale 1ns/1ps
module supply_start_seq_tb;
  localparam int CW = 4;
  localparam int WK = 8;
  localparam int ST = 3;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_in, lockout_in, hot_in;
  logic [CW-1:0] ref_code;
  logic          sw_en, gate_off, dis_en, start_done;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  supply_start_seq #(.CODE_W(CW), .WAKE_CYCLES(WK), .STEP_CYCLES(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .lockout_in(lockout_in),
    .hot_in(hot_in), .ref_code(ref_code), .sw_en(sw_en), .gate_off(gate_off),
    .dis_en(dis_en), .start_done(start_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en_in = 1'b0; lockout_in = 1'b0; hot_in = 1'b0;
    tick(2);
    chk("R1 code in reset", ref_code, 0);
    chk("R1 gate_off in reset", gate_off, 1);
    rst_n = 1'b1;
    tick(3);
    chk("R1 code idle", ref_code, 0);
    chk("R1 sw_en idle", sw_en, 0);
    chk("R1 done idle", start_done, 0);
    chk("R1 dis_en idle", dis_en, 1);
  endtask

  task automatic t_startup;
    en_in = 1'b1;
    #1 chk("R3 dis_en off when enabled", dis_en, 0);
    tick(WK);
    chk("R2 sw_en at last wake edge", sw_en, 0);
    chk("R2 code during wake", ref_code, 0);
    tick(1);
    chk("R2 sw_en after wake", sw_en, 1);
    chk("R2 gate_off after wake", gate_off, 0);
    tick(ST - 1);
    chk("R4 code before first step", ref_code, 0);
    tick(1);
    chk("R4 first step", ref_code, 1);
    tick(4 * ST);
    chk("R4 fifth step", ref_code, 5);
    tick(10 * ST);
    chk("R4 full scale", ref_code, FULL);
    chk("R5 done not yet", start_done, 0);
    tick(1);
    chk("R5 done set", start_done, 1);
    tick(5);
    chk("R5 done held", start_done, 1);
  endtask

  task automatic t_disable;
    en_in = 1'b0;
    #1;
    chk("R3 gate_off immediate", gate_off, 1);
    chk("R3 sw_en immediate", sw_en, 0);
    chk("R3 dis_en immediate", dis_en, 1);
    tick(1);
    chk("R9 done cleared on disable", start_done, 0);
    chk("R3 code zero after disable", ref_code, 0);
  endtask

  task automatic t_lockout;
    lockout_in = 1'b1; en_in = 1'b1;
    tick(WK + 5);
    chk("R6 no switching in lockout", sw_en, 0);
    chk("R6 code in lockout", ref_code, 0);
    chk("R6 no discharge when enabled", dis_en, 0);
    lockout_in = 1'b0;
    tick(3);
    lockout_in = 1'b1;
    tick(1);
    lockout_in = 1'b0;
    tick(WK);
    chk("R8 wake restarts from beginning", sw_en, 0);
    tick(1);
    chk("R8 switching after full wake", sw_en, 1);
    tick(3 * ST);
    chk("R4 code mid ramp", ref_code, 3);
    lockout_in = 1'b1;
    #1 chk("R8 gate_off on abort", gate_off, 1);
    tick(1);
    chk("R8 code zero after abort", ref_code, 0);
    chk("R8 sw_en after abort", sw_en, 0);
    lockout_in = 1'b0;
  endtask

  task automatic t_thermal;
    tick(WK + 1 + FULL * ST + 1);
    chk("R5 done before thermal", start_done, 1);
    hot_in = 1'b1;
    #1;
    chk("R7 gate_off on hot", gate_off, 1);
    chk("R7 no discharge on hot", dis_en, 0);
    tick(1);
    chk("R9 done cleared on hot", start_done, 0);
    chk("R7 code zero on hot", ref_code, 0);
    tick(20);
    chk("R7 stays off while hot", sw_en, 0);
    hot_in = 1'b0;
    tick(WK);
    chk("R7 wake after cooling", sw_en, 0);
    chk("R7 code zero in wake", ref_code, 0);
    tick(1);
    chk("R7 switching resumes", sw_en, 1);
    chk("R7 fresh ramp from zero", ref_code, 0);
    tick(ST);
    chk("R7 ramp first step", ref_code, 1);
    en_in = 1'b0;
    tick(2);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_disable();
    t_lockout();
    t_thermal();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule